// File: doc/BRIEF.md
# Per-Slave Bus Arbiter with Default Master

This block decides which of several bus masters owns one slave port of a multi-master interconnect. Each master raises a request line. The master that currently owns the port can also flag the final beat of its transfer. The arbiter returns a one-hot grant vector, held in a register. Pending requesters are served in round-robin order. A programmable slot timer stops a single master from holding the port forever while others wait.

When no connected master is requesting, an idle policy decides what the port stays attached to. It can detach completely. It can stay with the master that used it last. Or it can attach to one chosen master. A master that is already attached while the port is idle gets its first access without the extra grant cycle.

A small write port sets four things: the slot limit, the idle policy, the chosen idle master, and a mask of the masters wired to this slave. Requests from masters outside the mask have no effect.

Top module: `slv_port_arbiter`

## Requirements
- R1: After reset the grant is all zero, the slot limit is 0, the idle policy is 0, the chosen idle master is 0 and every master is connected.
- R2: The grant is one-hot or all zero and changes only at a clock edge. A request sampled at an edge while the port is detached shows up in the grant right after that same edge.
- R3: At each arbitration the winner is the first requesting connected master found by searching upward, with wrap-around, from the index after the most recently granted master.
- R4: While the current owner keeps requesting, does not flag its final beat and its slot has not run out, the grant does not change.
- R5: When the owner flags its final beat, an arbitration takes place at that edge, and a waiting master takes over the port.
- R6: With a slot limit L other than 0, the timer restarts at every arbitration. After the owner has held the port for L consecutive cycles, an arbitration is forced, so the owner loses the port to a waiting master. If no other master is waiting, the owner keeps the port.
- R7: With a slot limit of 0 the timer never forces an arbitration, and an owner that keeps requesting keeps the port until it flags its final beat.
- R8: Idle policy 0 detaches the port (grant all zero) whenever no connected master requests. The reserved policy 3 behaves the same way.
- R9: Idle policy 1 leaves the port attached to the most recently granted master while nothing is requested. That master's next request then keeps the grant with no gap.
- R10: Idle policy 2 attaches the idle port to the chosen idle master.
- R11: Under idle policy 2, if the chosen master's connect bit is 0, the port behaves as under policy 0.
- R12: A request from a master whose connect bit is 0 is never granted and never holds the port.
- R13: Write port addresses: 0 is the slot limit (low bits), 1 is the idle policy (bits 1:0), 2 is the chosen idle master index, and 3 is the connect mask (bit i for master i). A write takes effect from the next edge on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 2 | Configuration field select |
| cfg_wdata | input | CFG_DW | Configuration write data |
| mst_req | input | NUM_MST | Request line of each master |
| burst_end | input | 1 | Current owner's final beat |
| mst_gnt | output | NUM_MST | Registered one-hot grant, zero when detached |

## Verification
The bench counts how long an owner keeps the port against a waiting master, one slot cycle at a time. A timer that is off by one would hand the port over one cycle early or late, and a timer that ignored the zero setting would break bursts it must leave alone. The bench steps the idle port through every policy and checks what the port attaches to and whether a repeated access keeps its grant with no gap. A design that ignored the connect mask would attach to an unconnected chosen master or grant a masked requester. The bench also checks the wrap-around search order, so a design that restarted at index 0 would serve the wrong master after a final-beat flag.

// File: rtl/arb_pkg.sv
package arb_pkg;

  typedef enum logic [1:0] {
    DF_NONE  = 2'd0,
    DF_LAST  = 2'd1,
    DF_FIXED = 2'd2,
    DF_RSVD  = 2'd3
  } dflt_e;

  localparam logic [1:0] CA_SLOT  = 2'd0;
  localparam logic [1:0] CA_DTYPE = 2'd1;
  localparam logic [1:0] CA_FIXED = 2'd2;
  localparam logic [1:0] CA_MASK  = 2'd3;

endpackage

// File: rtl/arb_cfg_regs.sv
module arb_cfg_regs
  import arb_pkg::*;
#(
  parameter int NUM_MST = 4,
  parameter int SLOT_W  = 8,
  parameter int IDX_W   = 2,
  parameter int CFG_DW  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [1:0]        addr,
  input  logic [CFG_DW-1:0] wdata,
  output logic [SLOT_W-1:0] slot_lim,
  output dflt_e             dtype,
  output logic [IDX_W-1:0]  fixed_idx,
  output logic [NUM_MST-1:0] conn_mask
);

  always_ff @(posedge clk) begin
    if (rst) begin
      slot_lim  <= '0;
      dtype     <= DF_NONE;
      fixed_idx <= '0;
      conn_mask <= '1;
    end else if (we) begin
      case (addr)
        CA_SLOT:  slot_lim  <= wdata[SLOT_W-1:0];
        CA_DTYPE: dtype     <= dflt_e'(wdata[1:0]);
        CA_FIXED: fixed_idx <= wdata[IDX_W-1:0];
        default:  conn_mask <= wdata[NUM_MST-1:0];
      endcase
    end
  end

endmodule

// File: rtl/arb_slot_timer.sv
module arb_slot_timer #(
  parameter int SLOT_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [SLOT_W-1:0] lim,
  input  logic              reload,
  output logic              expire
);

  logic [SLOT_W-1:0] cnt;

  // Window ends once lim cycles of ownership have gone by.
  assign expire = (lim != '0) && (cnt >= (lim - 1'b1));

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (reload) begin
      cnt <= '0;
    end else if (cnt != '1) begin
      cnt <= cnt + 1'b1;
    end
  end

  assert_slot_window_R6: assert property (@(posedge clk) disable iff (rst)
    (lim != '0 && $stable(lim)) |-> (cnt < lim));

endmodule

// File: rtl/arb_rr_pick.sv
module arb_rr_pick #(
  parameter int NUM_MST = 4,
  parameter int IDX_W   = 2
) (
  input  logic [NUM_MST-1:0] req,
  input  logic [IDX_W-1:0]   ptr,
  output logic               found,
  output logic [IDX_W-1:0]   idx
);

  logic [IDX_W-1:0] cand;

  // Search starts one past ptr and wraps, so ptr itself is tried last.
  always_comb begin
    found = 1'b0;
    idx   = '0;
    cand  = '0;
    for (int k = 1; k <= NUM_MST; k++) begin
      cand = IDX_W'((int'(ptr) + k) % NUM_MST);
      if (!found && req[cand]) begin
        found = 1'b1;
        idx   = cand;
      end
    end
  end

endmodule

// File: rtl/slv_port_arbiter.sv
module slv_port_arbiter
  import arb_pkg::*;
#(
  parameter int NUM_MST = 4,
  parameter int SLOT_W  = 8,
  parameter int CFG_DW  = (SLOT_W > NUM_MST) ? SLOT_W : NUM_MST
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cfg_we,
  input  logic [1:0]         cfg_addr,
  input  logic [CFG_DW-1:0]  cfg_wdata,
  input  logic [NUM_MST-1:0] mst_req,
  input  logic               burst_end,
  output logic [NUM_MST-1:0] mst_gnt
);

  localparam int IDX_W = (NUM_MST > 1) ? $clog2(NUM_MST) : 1;

  logic [SLOT_W-1:0]  slot_lim;
  dflt_e              dtype;
  logic [IDX_W-1:0]   fixed_idx;
  logic [NUM_MST-1:0] conn_mask;

  logic [NUM_MST-1:0] gnt_q, gnt_d, idle_gnt, req_eff;
  logic [IDX_W-1:0]   last_q, last_d, gnt_idx, pick_idx;
  logic               last_vld_q, last_vld_d;
  logic               owner_active, arb_evt, slot_expire, pick_found, fixed_ok;

  arb_cfg_regs #(
    .NUM_MST(NUM_MST), .SLOT_W(SLOT_W), .IDX_W(IDX_W), .CFG_DW(CFG_DW)
  ) u_cfg (
    .clk(clk), .rst(rst), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
    .slot_lim(slot_lim), .dtype(dtype), .fixed_idx(fixed_idx),
    .conn_mask(conn_mask)
  );

  arb_slot_timer #(.SLOT_W(SLOT_W)) u_slot (
    .clk(clk), .rst(rst), .lim(slot_lim), .reload(arb_evt),
    .expire(slot_expire)
  );

  arb_rr_pick #(.NUM_MST(NUM_MST), .IDX_W(IDX_W)) u_pick (
    .req(req_eff), .ptr(last_q), .found(pick_found), .idx(pick_idx)
  );

  assign req_eff      = mst_req & conn_mask;
  assign owner_active = (gnt_q & req_eff) != '0;
  assign arb_evt      = !owner_active || burst_end || slot_expire;
  assign fixed_ok     = (int'(fixed_idx) < NUM_MST) && conn_mask[fixed_idx];

  always_comb begin
    gnt_idx = '0;
    for (int i = 0; i < NUM_MST; i++) begin
      if (gnt_q[i]) gnt_idx = IDX_W'(i);
    end
  end

  // Where the port rests when nobody connected is asking.
  always_comb begin
    idle_gnt = '0;
    case (dtype)
      DF_LAST:  if (last_vld_q && conn_mask[last_q]) idle_gnt = NUM_MST'(1) << last_q;
      DF_FIXED: if (fixed_ok) idle_gnt = NUM_MST'(1) << fixed_idx;
      default:  idle_gnt = '0;
    endcase
  end

  always_comb begin
    gnt_d      = gnt_q;
    last_d     = last_q;
    last_vld_d = last_vld_q;
    if (arb_evt) begin
      if (pick_found) begin
        gnt_d      = NUM_MST'(1) << pick_idx;
        last_d     = pick_idx;
        last_vld_d = 1'b1;
      end else begin
        gnt_d = idle_gnt;
      end
    end else begin
      last_d     = gnt_idx;
      last_vld_d = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      gnt_q      <= '0;
      last_q     <= '0;
      last_vld_q <= 1'b0;
    end else begin
      gnt_q      <= gnt_d;
      last_q     <= last_d;
      last_vld_q <= last_vld_d;
    end
  end

  assign mst_gnt = gnt_q;

  assert_grant_onehot_R2: assert property (@(posedge clk) disable iff (rst)
    $onehot0(gnt_q));

  assert_idle_disconnect_R8: assert property (@(posedge clk) disable iff (rst)
    ((dtype == DF_NONE || dtype == DF_RSVD) && req_eff == '0) |=> (gnt_q == '0));

  assert_no_slot_break_R7: assert property (@(posedge clk) disable iff (rst)
    (slot_lim == '0 && owner_active && !burst_end) |=> $stable(gnt_q));

  assert_grant_has_cause_R12: assert property (@(posedge clk) disable iff (rst)
    (gnt_q != $past(gnt_q) && gnt_q != '0) |->
      (((gnt_q & $past(req_eff)) != '0) || $past(dtype) == DF_LAST ||
       $past(dtype) == DF_FIXED));

endmodule

// File: tb/tb_slv_port_arbiter.sv
module tb_slv_port_arbiter;
  localparam int CLK_P = 10;
  localparam int N     = 4;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         cfg_we = 1'b0;
  logic [1:0]   cfg_addr = '0;
  logic [7:0]   cfg_wdata = '0;
  logic [N-1:0] req = '0;
  logic         bend = 1'b0;
  logic [N-1:0] gnt;

  int  n_tests = 0;
  int  n_fail  = 0;
  bit  done    = 0;

  logic [N:0] q_exp[$];
  string      q_tag[$];
  logic [N:0] m_e;
  string      m_t;

  slv_port_arbiter #(.NUM_MST(N), .SLOT_W(8)) dut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .mst_req(req), .burst_end(bend), .mst_gnt(gnt)
  );

  always #(CLK_P/2) clk = ~clk;

  // Driver: apply one cycle of stimulus and queue what the grant must be after the edge.
  task automatic cyc(input logic [N-1:0] r, input logic b, input logic chk,
                     input logic [N-1:0] e, input string t);
    req  = r;
    bend = b;
    q_exp.push_back({chk, e});
    q_tag.push_back(t);
    @(posedge clk);
    #1;
    cfg_we = 1'b0;
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    cfg_we    = 1'b1;
    cfg_addr  = a;
    cfg_wdata = d;
    cyc('0, 1'b0, 1'b0, '0, "cfg");
  endtask

  // Monitor: compare the registered grant shortly after each edge.
  always @(posedge clk) begin
    #2;
    if (q_exp.size() != 0) begin
      m_e = q_exp.pop_front();
      m_t = q_tag.pop_front();
      if (m_e[N]) begin
        n_tests++;
        if (gnt !== m_e[N-1:0]) begin
          n_fail++;
          $display("FAIL %s: gnt=%b expected %b", m_t, gnt, m_e[N-1:0]);
        end
      end
    end
  end

  initial begin
    repeat (3000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL R2 watchdog: actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    rst = 1'b1;
    cyc('0, 0, 0, '0, "rst");
    cyc('0, 0, 0, '0, "rst");
    rst = 1'b0;

    // Reset state
    cyc(4'b0000, 0, 1, 4'b0000, "R1 grant zero after reset");
    cyc(4'b1000, 0, 1, 4'b1000, "R1 R2 all connected, grant one cycle later");
    cyc(4'b0000, 0, 1, 4'b0000, "R8 detach when idle");

    // Round robin and final-beat handover
    cyc(4'b0011, 0, 1, 4'b0001, "R3 wrap from m3 to m0");
    cyc(4'b0011, 0, 1, 4'b0001, "R4 owner holds");
    cyc(4'b0011, 1, 1, 4'b0010, "R5 final beat hands to m1");
    cyc(4'b0011, 1, 1, 4'b0001, "R3 after m1 search wraps to m0");
    cyc(4'b0000, 0, 1, 4'b0000, "R8 detach");
    cyc(4'b1111, 0, 1, 4'b0010, "R3 start after m0");
    cyc(4'b1111, 1, 1, 4'b0100, "R3 rotate m2");
    cyc(4'b1111, 1, 1, 4'b1000, "R3 rotate m3");
    cyc(4'b1111, 1, 1, 4'b0001, "R3 rotate m0");
    cyc(4'b0000, 0, 1, 4'b0000, "R8 detach");

    // Slot limit 3
    wr(2'd0, 8'd3);
    cyc(4'b0001, 0, 1, 4'b0001, "R6 m0 gets port");
    cyc(4'b0011, 0, 1, 4'b0001, "R6 cycle 2 of slot");
    cyc(4'b0011, 0, 1, 4'b0001, "R6 cycle 3 of slot");
    cyc(4'b0011, 0, 1, 4'b0010, "R6 slot expired, m1 takes over");
    cyc(4'b0011, 0, 1, 4'b0010, "R6 m1 cycle 2");
    cyc(4'b0011, 0, 1, 4'b0010, "R6 m1 cycle 3");
    cyc(4'b0011, 0, 1, 4'b0001, "R6 m1 slot expired, back to m0");
    for (int i = 0; i < 5; i++) cyc(4'b0001, 0, 1, 4'b0001, "R6 lone owner keeps port");
    cyc(4'b0000, 0, 1, 4'b0000, "R8 detach");

    // Slot limit 0
    wr(2'd0, 8'd0);
    cyc(4'b0001, 0, 1, 4'b0001, "R7 m0 gets port");
    for (int i = 0; i < 8; i++) cyc(4'b0011, 0, 1, 4'b0001, "R7 no slot break");
    cyc(4'b0011, 1, 1, 4'b0010, "R7 R5 only final beat hands over");
    cyc(4'b0000, 0, 1, 4'b0000, "R8 detach");

    // Idle policy 1
    wr(2'd1, 8'd1);
    cyc(4'b0000, 0, 1, 4'b0010, "R9 R13 stay with last master m1");
    cyc(4'b0010, 0, 1, 4'b0010, "R9 repeat access without gap");
    cyc(4'b0100, 0, 1, 4'b0100, "R9 new master m2");
    cyc(4'b0000, 0, 1, 4'b0100, "R9 remains on m2");

    // Idle policy 2, chosen master 3
    wr(2'd2, 8'd3);
    wr(2'd1, 8'd2);
    cyc(4'b0000, 0, 1, 4'b1000, "R10 R13 idle to chosen m3");
    cyc(4'b1000, 0, 1, 4'b1000, "R10 chosen master keeps grant");
    cyc(4'b0001, 0, 1, 4'b0001, "R10 m0 request served");
    cyc(4'b0000, 0, 1, 4'b1000, "R10 back to chosen m3");

    // Connect mask excludes m3
    wr(2'd3, 8'b0111);
    cyc(4'b0000, 0, 1, 4'b0000, "R11 R13 chosen master unconnected, detach");
    cyc(4'b1000, 0, 1, 4'b0000, "R12 masked request ignored");
    cyc(4'b1001, 0, 1, 4'b0001, "R12 only connected m0 granted");
    cyc(4'b1000, 0, 1, 4'b0000, "R12 R11 masked m3 holds nothing");

    // Reserved policy 3
    wr(2'd3, 8'b1111);
    wr(2'd1, 8'd3);
    cyc(4'b0000, 0, 1, 4'b0000, "R8 reserved policy detaches");

    cyc(4'b0000, 0, 0, '0, "drain");
    repeat (2) @(posedge clk);
    #5;
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule